// File: doc/BRIEF.md
# DAC sample FIFO controller

This block feeds a 12-bit converter input latch from samples written over a simple register bus. Each write to the sample address pushes the low 12 bits into a FIFO whose depth is fixed at build time. Each honoured conversion trigger moves one sample into the output latch. A trigger is either a strobe on a hardware pin or a one-shot bit written through the control word. A control bit picks which of the two is used.

The control word stores the configuration and the status. The status flags are full, nearly empty, watermark, and two sticky flags for overflow and underflow. Each flag has an interrupt enable, and the enabled flag events are routed either to an interrupt line or to a DMA request line. The control word also holds a FIFO flush, a soft reset, a single-level bypass mode and a replay mode, in which the stored sample sequence is played again and again. The read and write pointers can be read back in a separate word.

Register map, word addressed: 0 holds the depth code, 1 is the sample register, 2 is the control/status word and 3 holds the pointers. Reads are combinational on `bus_addr`.

Top module: `dac_sample_fifo`

## Requirements
- R1: The depth is 2^(DEPTH_CODE+1) entries. DEPTH_CODE reads at address 0, bits [2:0]. After reset the FIFO is empty, both pointers are 0, all configuration is 0 and `conv_code` is 0.
- R2: A bus write to address 1 pushes bits [11:0]. On the clock edge of each honoured trigger that finds data, the oldest sample appears on `conv_code`, and `conv_strobe` is high for that one cycle.
- R3: A push while the FIFO is full, with no pop on the same edge, is dropped and sets the sticky overflow flag, control bit 4. Control bit 0 reads 1 when the occupancy equals the capacity.
- R4: In normal mode, a trigger that finds the FIFO empty sets the sticky underflow flag, control bit 3, and leaves `conv_code` and the read pointer unchanged.
- R5: Writing 1 to control bit 3 or bit 4 clears that sticky flag. When a new event for the same flag occurs on the same edge, the flag stays set.
- R6: Control bit 1 (nearly empty) reads 1 exactly when one sample is held.
- R7: Control bit 2 (watermark) reads 1 when the read pointer equals the level in control bits [31:24].
- R8: Control bit 13 selects the trigger source: 0 selects `hw_trig`, 1 selects a one-cycle pulse made by writing 1 to bit 12. The unselected source is ignored. Bit 12 reads 0. While enable (bit 15) is 0, no trigger is honoured: no pop and no underflow.
- R9: With FIFO enable (bit 16) at 0, the capacity is one sample. A second push before a trigger overflows.
- R10: With bit 17 and bit 16 both set (replay), a trigger that finds the read pointer equal to the write pointer restarts at entry 0. Replay reads do not consume samples and never set underflow.
- R11: The flag events are gated by enables: full by bit 8, nearly empty by bit 9, watermark by bit 10, and under/overflow by bit 18. They drive `irq` when bit 23 is 0. When bit 23 is 1 they drive `dma_req` instead, and `irq` is held low.
- R12: Writing 1 to bit 21 empties the FIFO and zeroes both pointers. Writing 1 to bit 22 returns the whole block to its reset state. Both bits read 0.
- R13: Address 3 returns the write pointer in bits [7:0] and the read pointer in bits [23:16]. A push and a pop on the same edge while the FIFO is full are both accepted, and the occupancy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| hw_trig | input | 1 | Hardware conversion trigger, one cycle per trigger |
| conv_code | output | 12 | Converter input latch |
| conv_strobe | output | 1 | High for the cycle after a latch update |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A sample push and a conversion trigger can land on the same clock edge. The outcome differs when the FIFO is full, where both must be accepted without overflow, and when it is empty, where the trigger underflows but the push is still stored. The random phase drives pushes and hardware triggers independently, with biases that repeatedly drive the FIFO to full and to empty. A directed case forces a push and a trigger together at exactly full. The bench model decides each outcome per edge and compares the latch, the flags and both pointers after every cycle. The clear of a sticky flag arriving together with a new underflow is also provoked directly.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  localparam int SAMPLE_W = 12;
  localparam int BUS_W    = 32;

  typedef enum logic [1:0] {
    A_INFO   = 2'd0,
    A_SAMPLE = 2'd1,
    A_CTRL   = 2'd2,
    A_PTRS   = 2'd3
  } addr_e;

  // control/status word bit positions (software decodes these)
  localparam int B_FULL    = 0;
  localparam int B_NEMPTY  = 1;
  localparam int B_WMARK   = 2;
  localparam int B_UNDER   = 3;
  localparam int B_OVER    = 4;
  localparam int B_FULL_IE = 8;
  localparam int B_NE_IE   = 9;
  localparam int B_WM_IE   = 10;
  localparam int B_SWTRIG  = 12;
  localparam int B_TSEL    = 13;
  localparam int B_ENA     = 15;
  localparam int B_FIFO_EN = 16;
  localparam int B_REPLAY  = 17;
  localparam int B_UV_IE   = 18;
  localparam int B_FLUSH   = 21;
  localparam int B_SRST    = 22;
  localparam int B_DMA     = 23;
  localparam int B_WML_LO  = 24;

  typedef struct packed {
    logic [7:0] wml;
    logic       dma_en;
    logic       uv_ie;
    logic       replay;
    logic       fifo_en;
    logic       enable;
    logic       tsel;
    logic       wm_ie;
    logic       ne_ie;
    logic       full_ie;
  } ctrl_t;

  typedef struct packed {
    logic ovf;
    logic udf;
    logic wmark;
    logic nempty;
    logic full;
  } flags_t;

  function automatic int depth_of(input int code);
    return 1 << (code + 1);
  endfunction

  function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
    ctrl_t c;
    c.wml     = w[B_WML_LO +: 8];
    c.dma_en  = w[B_DMA];
    c.uv_ie   = w[B_UV_IE];
    c.replay  = w[B_REPLAY];
    c.fifo_en = w[B_FIFO_EN];
    c.enable  = w[B_ENA];
    c.tsel    = w[B_TSEL];
    c.wm_ie   = w[B_WM_IE];
    c.ne_ie   = w[B_NE_IE];
    c.full_ie = w[B_FULL_IE];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c, input flags_t f);
    logic [BUS_W-1:0] w;
    w = '0;
    w[B_WML_LO +: 8] = c.wml;
    w[B_DMA]     = c.dma_en;
    w[B_UV_IE]   = c.uv_ie;
    w[B_REPLAY]  = c.replay;
    w[B_FIFO_EN] = c.fifo_en;
    w[B_ENA]     = c.enable;
    w[B_TSEL]    = c.tsel;
    w[B_WM_IE]   = c.wm_ie;
    w[B_NE_IE]   = c.ne_ie;
    w[B_FULL_IE] = c.full_ie;
    w[B_OVER]    = f.ovf;
    w[B_UNDER]   = f.udf;
    w[B_WMARK]   = f.wmark;
    w[B_NEMPTY]  = f.nempty;
    w[B_FULL]    = f.full;
    return w;
  endfunction

endpackage

// File: rtl/dsf_store.sv
module dsf_store
  import dsf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  localparam int CNT_W = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] push_data,
  input  logic                trig,
  input  logic                bypass,
  input  logic                replay,
  output logic [CNT_W-1:0]    count,
  output logic [AW-1:0]       wr_ptr,
  output logic [AW-1:0]       rd_ptr,
  output logic                full,
  output logic                pop_fire,
  output logic [SAMPLE_W-1:0] pop_data,
  output logic                ovf_evt,
  output logic                udf_evt
);

  logic [SAMPLE_W-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] occ_next(input logic [CNT_W-1:0] c,
                                                input logic add, input logic sub);
    return c + CNT_W'(add) - CNT_W'(sub);
  endfunction

  logic          replay_eff;
  logic          empty;
  logic          pop_drain;
  logic          push_ok;
  logic [AW-1:0] rd_idx;

  assign replay_eff = replay & ~bypass;
  assign empty      = (count == '0);
  assign full       = bypass ? ~empty : (count == CNT_W'(DEPTH));
  assign pop_fire   = trig & ~empty;
  assign pop_drain  = pop_fire & ~replay_eff;
  assign rd_idx     = (replay_eff && (rd_ptr == wr_ptr)) ? '0 : rd_ptr;
  assign pop_data   = mem[rd_idx];
  assign push_ok    = push & (~full | pop_drain);
  assign ovf_evt    = push & full & ~pop_drain;
  assign udf_evt    = trig & empty & ~replay_eff;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok)  wr_ptr <= ptr_inc(wr_ptr);
      if (pop_fire) rd_ptr <= ptr_inc(rd_idx);
      count <= occ_next(count, push_ok, pop_drain);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  // R3: a dropped push leaves the write pointer where it was
  assert_overflow_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !flush) |=> $stable(wr_ptr));

  // R4: an empty trigger does not move the read pointer
  assert_underflow_keeps_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_evt && !flush) |=> $stable(rd_ptr));

  // R10: replay reads do not consume samples
  assert_replay_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && replay_eff && !push && !flush) |=> $stable(count));

  // R12: a flush leaves an empty FIFO with zeroed pointers
  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && wr_ptr == '0 && rd_ptr == '0));

  // R13: a full push alongside a draining pop keeps occupancy
  assert_full_pushpop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && pop_drain && !flush) |=> $stable(count));

endmodule

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [BUS_W-1:0] wdata,
  input  logic             ovf_evt,
  input  logic             udf_evt,
  output ctrl_t            cfg,
  output logic             ovf_flag,
  output logic             udf_flag,
  output logic             sw_trig,
  output logic             flush,
  output logic             srst
);

  logic clr_ovf;
  logic clr_udf;

  assign srst    = ctrl_we & wdata[B_SRST];
  assign flush   = (ctrl_we & wdata[B_FLUSH]) | srst;
  assign sw_trig = ctrl_we & wdata[B_SWTRIG] & ~srst;
  assign clr_ovf = ctrl_we & wdata[B_OVER];
  assign clr_udf = ctrl_we & wdata[B_UNDER];

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      cfg      <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      if (ctrl_we) cfg <= word_to_ctrl(wdata);
      ovf_flag <= ovf_evt | (ovf_flag & ~clr_ovf);
      udf_flag <= udf_evt | (udf_flag & ~clr_udf);
    end
  end

  // R3: overflow flag only rises after an overflow event
  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ovf_evt));

  // R5: sticky flags hold until cleared or soft reset
  assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !clr_udf && !srst) |=> udf_flag);

  // R5: a same-edge event beats the clear
  assert_ovf_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && clr_ovf && !srst) |=> ovf_flag);

endmodule

// File: rtl/dsf_route.sv
module dsf_route
  import dsf_pkg::*;
(
  input  ctrl_t  cfg,
  input  flags_t flg,
  output logic   irq,
  output logic   dma_req
);

  logic want;

  assign want = (flg.full   & cfg.full_ie)
              | (flg.nempty & cfg.ne_ie)
              | (flg.wmark  & cfg.wm_ie)
              | ((flg.ovf | flg.udf) & cfg.uv_ie);

  assign irq     = want & ~cfg.dma_en;
  assign dma_req = want &  cfg.dma_en;

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
  import dsf_pkg::*;
#(
  parameter int DEPTH_CODE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                hw_trig,
  output logic [SAMPLE_W-1:0] conv_code,
  output logic                conv_strobe,
  output logic                irq,
  output logic                dma_req
);

  localparam int DEPTH = depth_of(DEPTH_CODE);
  localparam int AW    = DEPTH_CODE + 1;
  localparam int CNT_W = AW + 1;

  if (DEPTH_CODE < 0 || DEPTH_CODE > 7) begin : g_code_check
    $error("DEPTH_CODE must lie in 0..7");
  end

  // named internal events
  logic                data_we;
  logic                ctrl_we;
  logic                trig;
  logic                sw_trig;
  logic                flush;
  logic                srst;
  logic                pop_fire;
  logic                ovf_evt;
  logic                udf_evt;
  logic                full;
  logic                ovf_flag;
  logic                udf_flag;
  logic [SAMPLE_W-1:0] pop_data;
  logic [CNT_W-1:0]    count;
  logic [AW-1:0]       wr_ptr;
  logic [AW-1:0]       rd_ptr;
  ctrl_t               cfg;
  flags_t              flg;

  assign data_we = bus_we && (bus_addr == A_SAMPLE);
  assign ctrl_we = bus_we && (bus_addr == A_CTRL);
  assign trig    = cfg.enable & (cfg.tsel ? sw_trig : hw_trig);

  dsf_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .wdata    (bus_wdata),
    .ovf_evt  (ovf_evt),
    .udf_evt  (udf_evt),
    .cfg      (cfg),
    .ovf_flag (ovf_flag),
    .udf_flag (udf_flag),
    .sw_trig  (sw_trig),
    .flush    (flush),
    .srst     (srst)
  );

  dsf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (data_we),
    .push_data (bus_wdata[SAMPLE_W-1:0]),
    .trig      (trig),
    .bypass    (~cfg.fifo_en),
    .replay    (cfg.replay),
    .count     (count),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .full      (full),
    .pop_fire  (pop_fire),
    .pop_data  (pop_data),
    .ovf_evt   (ovf_evt),
    .udf_evt   (udf_evt)
  );

  assign flg.full   = full;
  assign flg.nempty = (count == CNT_W'(1));
  assign flg.wmark  = (8'(rd_ptr) == cfg.wml);
  assign flg.udf    = udf_flag;
  assign flg.ovf    = ovf_flag;

  dsf_route u_route (
    .cfg     (cfg),
    .flg     (flg),
    .irq     (irq),
    .dma_req (dma_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      conv_code   <= '0;
      conv_strobe <= 1'b0;
    end else begin
      conv_strobe <= pop_fire;
      if (pop_fire) conv_code <= pop_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr_e'(bus_addr))
      A_INFO:   bus_rdata[2:0] = 3'(DEPTH_CODE);
      A_SAMPLE: bus_rdata[SAMPLE_W-1:0] = conv_code;
      A_CTRL:   bus_rdata = ctrl_to_word(cfg, flg);
      A_PTRS:   bus_rdata = {8'h00, 8'(rd_ptr), 8'h00, 8'(wr_ptr)};
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a latch update is always caused by a trigger one edge earlier
  assert_strobe_from_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> $past(trig));

  // R8: with the block disabled nothing reaches the latch
  assert_disabled_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.enable |=> !conv_strobe);

endmodule

// File: tb/dac_sample_fifo_tb.sv
module dac_sample_fifo_tb;

  localparam int CODE  = 2;
  localparam int DEPTH = 8;

  localparam logic [31:0] K_EN     = 32'h0000_8000;
  localparam logic [31:0] K_FIFO   = 32'h0001_0000;
  localparam logic [31:0] K_TSEL   = 32'h0000_2000;
  localparam logic [31:0] K_SWT    = 32'h0000_1000;
  localparam logic [31:0] K_REPLAY = 32'h0002_0000;
  localparam logic [31:0] K_UVIE   = 32'h0004_0000;
  localparam logic [31:0] K_WMIE   = 32'h0000_0400;
  localparam logic [31:0] K_FLUSH  = 32'h0020_0000;
  localparam logic [31:0] K_SRST   = 32'h0040_0000;
  localparam logic [31:0] K_DMA    = 32'h0080_0000;
  localparam logic [31:0] K_CLRU   = 32'h0000_0008;
  localparam logic [31:0] K_CLRO   = 32'h0000_0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic        hw_trig = 1'b0;
  logic [31:0] bus_rdata;
  logic [11:0] conv_code;
  logic        conv_strobe;
  logic        irq;
  logic        dma_req;

  always #5 clk = ~clk;

  dac_sample_fifo #(.DEPTH_CODE(CODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
    .conv_code(conv_code), .conv_strobe(conv_strobe), .irq(irq), .dma_req(dma_req)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  int m_cnt, m_wr, m_rd, m_conv;
  bit m_udf, m_ovf;
  int m_q [DEPTH];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] st(int cnt, int cap, int rdp, int wml, bit udf, bit ovf);
    return {27'b0, ovf, udf, rdp == wml, cnt == 1, cnt == cap};
  endfunction

  task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d, input bit hw);
    bus_we = we; bus_addr = a; bus_wdata = d; hw_trig = hw;
    @(negedge clk);
    bus_we = 1'b0; hw_trig = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic model_step(input bit push, input int d, input bit trg);
    bit pop, pok;
    pop = trg && (m_cnt > 0);
    if (trg && m_cnt == 0) m_udf = 1'b1;
    pok = push && (m_cnt < DEPTH || pop);
    if (push && m_cnt == DEPTH && !pop) m_ovf = 1'b1;
    if (pop) begin m_conv = m_q[m_rd]; m_rd = (m_rd + 1) % DEPTH; end
    if (pok) begin m_q[m_wr] = d; m_wr = (m_wr + 1) % DEPTH; end
    m_cnt = m_cnt + int'(pok) - int'(pop);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); chk("R1 depth code", v, 32'd2);
    peek(2'd2, v); chk("R1 reset ctrl", v, st(0, DEPTH, 0, 0, 0, 0));
    peek(2'd3, v); chk("R1 reset ptrs", v, 32'd0);
    chk("R1 reset latch", {20'b0, conv_code}, 32'd0);
    chk("R1 reset irq", {irq, dma_req}, 32'd0);

    // random mix: R2 R3 R4 R6 R7 R13
    step(1, 2'd2, K_EN | K_FIFO, 0);
    m_cnt = 0; m_wr = 0; m_rd = 0; m_conv = 0; m_udf = 0; m_ovf = 0;
    for (int i = 0; i < 400; i++) begin
      bit p, t;
      int d;
      p = (i < 200) ? (($urandom % 2) == 0) : (($urandom % 4) == 0);
      t = (i < 200) ? (($urandom % 3) == 0) : (($urandom % 2) == 0);
      d = int'($urandom % 4096);
      if (p) step(1, 2'd1, 32'(d), t); else step(0, 2'd0, 32'd0, t);
      model_step(p, d, t);
      chk("R2 latch random", {20'b0, conv_code}, 32'(m_conv));
      peek(2'd2, v);
      chk("R3/R4/R6/R7 flags random", v & 32'h1F, st(m_cnt, DEPTH, m_rd, 0, m_udf, m_ovf));
      peek(2'd3, v);
      chk("R13 pointers random", v, 32'((m_rd << 16) | m_wr));
    end
    peek(2'd2, v); chk("R8 ctrl readback", v & ~32'h1F, K_EN | K_FIFO);

    // R13 full push+pop same edge
    step(1, 2'd2, K_EN | K_FIFO | K_FLUSH | K_CLRU | K_CLRO, 0);
    peek(2'd3, v); chk("R12 flush ptrs", v, 32'd0);
    for (int i = 0; i < DEPTH; i++) step(1, 2'd1, 32'h100 + 32'(i), 0);
    peek(2'd2, v); chk("R3 full flag", v & 32'h1F, st(8, 8, 0, 0, 0, 0));
    step(1, 2'd1, 32'hABC, 1);
    chk("R13 pop at full", {20'b0, conv_code}, 32'h100);
    peek(2'd2, v); chk("R13 no overflow", v & 32'h1F, st(8, 8, 1, 0, 0, 0));
    peek(2'd3, v); chk("R13 ptrs", v, 32'h0001_0001);

    // R7 watermark
    step(1, 2'd2, 32'h0300_0000 | K_EN | K_FIFO, 0);
    peek(2'd2, v); chk("R7 below mark", v & 32'h1F, st(8, 8, 1, 3, 0, 0));
    step(0, 2'd0, 0, 1); step(0, 2'd0, 0, 1);
    chk("R2 order", {20'b0, conv_code}, 32'h102);
    peek(2'd2, v); chk("R7 at mark", v & 32'h1F, st(6, 8, 3, 3, 0, 0));

    // R8 disabled
    step(1, 2'd2, 32'h0300_0000 | K_FIFO, 0);
    step(0, 2'd0, 0, 1);
    chk("R8 disabled latch", {20'b0, conv_code}, 32'h102);
    peek(2'd3, v); chk("R8 disabled ptrs", v, 32'h0003_0001);

    // R8 software trigger
    step(1, 2'd2, 32'h0300_0000 | K_EN | K_FIFO | K_TSEL, 0);
    step(0, 2'd0, 0, 1);
    chk("R8 hw ignored", {20'b0, conv_code}, 32'h102);
    step(1, 2'd2, 32'h0300_0000 | K_EN | K_FIFO | K_TSEL | K_SWT, 0);
    chk("R8 sw trigger", {20'b0, conv_code}, 32'h103);
    chk("R2 strobe high", {31'b0, conv_strobe}, 32'd1);
    peek(2'd2, v); chk("R8 swtrig reads 0", v & ~32'h1F, 32'h0300_0000 | K_EN | K_FIFO | K_TSEL);
    step(0, 2'd0, 0, 0);
    chk("R2 strobe low", {31'b0, conv_strobe}, 32'd0);

    // R4 R5 underflow and clear
    step(1, 2'd2, K_EN | K_FIFO | K_FLUSH | K_CLRU | K_CLRO, 0);
    step(0, 2'd0, 0, 1);
    peek(2'd2, v); chk("R4 underflow set", v & 32'h1F, st(0, 8, 0, 0, 1, 0));
    chk("R4 latch held", {20'b0, conv_code}, 32'h103);
    step(1, 2'd2, K_EN | K_FIFO | K_CLRU, 1);
    peek(2'd2, v); chk("R5 set beats clear", v & 32'h1F, st(0, 8, 0, 0, 1, 0));
    step(1, 2'd2, K_EN | K_FIFO | K_CLRU, 0);
    peek(2'd2, v); chk("R5 cleared", v & 32'h1F, st(0, 8, 0, 0, 0, 0));

    // R11 routing (watermark flag is up: rd 0 == level 0)
    step(1, 2'd2, K_EN | K_FIFO | K_WMIE, 0);
    chk("R11 irq", {30'b0, irq, dma_req}, 32'h2);
    step(1, 2'd2, K_EN | K_FIFO | K_WMIE | K_DMA, 0);
    chk("R11 dma", {30'b0, irq, dma_req}, 32'h1);
    step(1, 2'd2, K_EN | K_FIFO | K_UVIE, 0);
    chk("R11 masked", {30'b0, irq, dma_req}, 32'h0);

    // R9 bypass
    step(1, 2'd2, K_EN | K_FLUSH | K_CLRU | K_CLRO, 0);
    step(1, 2'd1, 32'h011, 0);
    peek(2'd2, v); chk("R9 one level full", v & 32'h1F, st(1, 1, 0, 0, 0, 0));
    step(1, 2'd1, 32'h022, 0);
    peek(2'd2, v); chk("R9 second push overflows", v & 32'h1F, st(1, 1, 0, 0, 0, 1));
    step(0, 2'd0, 0, 1);
    chk("R9 first kept", {20'b0, conv_code}, 32'h011);
    step(1, 2'd2, K_EN | K_UVIE, 0);
    chk("R11 overflow irq", {30'b0, irq, dma_req}, 32'h2);

    // R10 replay
    step(1, 2'd2, K_EN | K_FIFO | K_REPLAY | K_FLUSH | K_CLRU | K_CLRO, 0);
    step(1, 2'd1, 32'hA01, 0); step(1, 2'd1, 32'hA02, 0); step(1, 2'd1, 32'hA03, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, 2'd0, 0, 1);
      chk("R10 replay order", {20'b0, conv_code}, 32'hA01 + 32'(i % 3));
    end
    peek(2'd2, v); chk("R10 no consume no underflow", v & 32'h1F, st(3, 8, 2, 0, 0, 0));
    peek(2'd3, v); chk("R10 ptrs", v, 32'h0002_0003);

    // R12 soft reset
    step(1, 2'd2, K_SRST | K_EN | K_FIFO, 0);
    peek(2'd2, v); chk("R12 soft reset ctrl", v, st(0, 8, 0, 0, 0, 0));
    peek(2'd3, v); chk("R12 soft reset ptrs", v, 32'd0);
    chk("R12 soft reset latch", {20'b0, conv_code}, 32'd0);

    done = 1'b1;
    report();
    $finish;
  end

endmodule